// File: doc/BRIEF.md
# Packetized Counting Stream Generator

This block sources a test stream on an AXI4-Stream master port for a stream-to-memory DMA engine that moves one fixed-length transfer per packet. Control logic supplies three settings: the packet length in beats (written as length minus one), the number of packets in a run (written as count minus one) and a minimum spacing between beats. A single start pulse then produces all packets of the run back to back. The data word is a running count that software can check after the transfer.

Packet boundaries come from a beat counter whose rollover point is the programmed length. That counter alone produces tlast, so tlast marks the final beat of each packet and no other beat, and the DMA transfer length and the stream packet length always agree. A busy output stays high for the whole run. A synchronous clear input returns the block to idle at any time.

Top module: `axis_pktgen`

## Requirements
- R1: While `rst_n` is low, and after it is released, `busy`, `m_tvalid` and `m_tlast` are 0 until a start is accepted.
- R2: When idle, a cycle with `ctl_start`=1 and `ctl_clear`=0 makes `busy` 1 from the next cycle. With a spacing of zero, `m_tvalid` is also 1 from that cycle.
- R3: With a length setting of L, beats in a packet are numbered 0 to L. `m_tlast` is 1 on beat L only.
- R4: With a count setting of P, the run holds exactly P+1 packets, which is (L+1)(P+1) accepted beats. `busy` falls in the cycle after the final beat of the last packet is accepted.
- R5: `m_tdata` is 0 on the first beat of each run and rises by one, modulo 2^DATA_W, on every accepted beat, across packet boundaries.
- R6: While `m_tvalid`=1 and `m_tready`=0, `m_tvalid`, `m_tdata` and `m_tlast` hold their values.
- R7: With a spacing setting of G, `m_tvalid` stays 0 for G cycles after each accepted beat, so a beat is offered at most once every G+1 cycles.
- R8: A `ctl_start` pulse while `busy`=1 has no effect. All three settings are captured at start, so changing them mid-run has no effect on that run.
- R9: With L=0, every beat carries `m_tlast`=1.
- R10: `ctl_clear`=1 makes `busy` and `m_tvalid` 0 in the next cycle. It takes priority over a start in the same cycle.
- R11: `m_tvalid` is 1 only while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_clear | input | 1 | Synchronous return to idle |
| ctl_start | input | 1 | Begins a run when idle |
| cfg_beats_m1 | input | BEAT_W | Beats per packet minus one |
| cfg_pkts_m1 | input | PKT_W | Packets per run minus one |
| cfg_gap | input | GAP_W | Idle cycles forced after each accepted beat |
| busy | output | 1 | Run in progress |
| m_tvalid | output | 1 | Stream valid |
| m_tready | input | 1 | Stream ready from the sink |
| m_tdata | output | DATA_W | Running count |
| m_tlast | output | 1 | Final beat of a packet |

## Verification
A wrong beat or packet count shows up at the port within one packet: tlast lands on a different beat than the reference expects, or busy falls early or late at the run's end. A corrupted data counter shows as a tdata mismatch on the very next offered beat. A broken spacing counter shows as tvalid appearing a cycle early or late after an accepted beat. The bench drives random backpressure and compares every output against a behavioural reference on every cycle, so any such divergence is reported in the cycle it first appears.

// File: rtl/pktgen_pkg.sv
package pktgen_pkg;
  typedef enum logic {
    RUN_IDLE   = 1'b0,
    RUN_ACTIVE = 1'b1
  } run_state_e;
endpackage

// File: rtl/pktgen_seq.sv
module pktgen_seq
  import pktgen_pkg::*;
#(
  parameter int BEAT_W = 16,
  parameter int PKT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              start,
  input  logic [BEAT_W-1:0] beats_m1,
  input  logic [PKT_W-1:0]  pkts_m1,
  input  logic              accept,
  output logic              launch,
  output logic              busy,
  output logic              last
);
  run_state_e        state_q, state_d;
  logic [BEAT_W-1:0] beat_q, beat_d, beats_q, beats_d;
  logic [PKT_W-1:0]  pkt_q, pkt_d, pkts_q, pkts_d;
  logic              beat_wrap;
  logic              run_done;

  assign launch    = start && (state_q == RUN_IDLE) && !clear;
  assign beat_wrap = (beat_q == beats_q);
  assign run_done  = (pkt_q == pkts_q);
  assign busy      = (state_q == RUN_ACTIVE);
  assign last      = busy && beat_wrap;

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    pkt_d   = pkt_q;
    beats_d = beats_q;
    pkts_d  = pkts_q;
    if (clear) begin
      state_d = RUN_IDLE;
      beat_d  = '0;
      pkt_d   = '0;
    end else if (launch) begin
      state_d = RUN_ACTIVE;
      beat_d  = '0;
      pkt_d   = '0;
      beats_d = beats_m1;
      pkts_d  = pkts_m1;
    end else if (accept && busy) begin
      if (beat_wrap) begin
        beat_d = '0;
        if (run_done) begin
          state_d = RUN_IDLE;
          pkt_d   = '0;
        end else begin
          pkt_d = pkt_q + 1'b1;
        end
      end else begin
        beat_d = beat_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RUN_IDLE;
      beat_q  <= '0;
      pkt_q   <= '0;
      beats_q <= '0;
      pkts_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      pkt_q   <= pkt_d;
      beats_q <= beats_d;
      pkts_q  <= pkts_d;
    end
  end
endmodule

// File: rtl/pktgen_pacer.sv
module pktgen_pacer #(
  parameter int GAP_W   = 8,
  parameter bit PACE_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             launch,
  input  logic             accept,
  input  logic [GAP_W-1:0] gap,
  output logic             ready
);
  generate
    if (PACE_EN) begin : g_pace
      logic [GAP_W-1:0] gap_q, gap_d;
      logic [GAP_W-1:0] wait_q, wait_d;

      always_comb begin
        gap_d  = gap_q;
        wait_d = wait_q;
        if (clear) begin
          wait_d = '0;
        end else if (launch) begin
          gap_d  = gap;
          wait_d = '0;
        end else if (accept) begin
          wait_d = gap_q;
        end else if (wait_q != '0) begin
          wait_d = wait_q - 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          gap_q  <= '0;
          wait_q <= '0;
        end else begin
          gap_q  <= gap_d;
          wait_q <= wait_d;
        end
      end

      assign ready = (wait_q == '0);
    end else begin : g_free
      logic unused_in;
      assign unused_in = clk ^ rst_n ^ clear ^ launch ^ accept ^ (^gap);
      assign ready     = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/pktgen_data.sv
module pktgen_data #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              launch,
  input  logic              accept,
  output logic [DATA_W-1:0] data
);
  logic [DATA_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear || launch) begin
      cnt_d = '0;
    end else if (accept) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign data = cnt_q;
endmodule

// File: rtl/axis_pktgen.sv
module axis_pktgen #(
  parameter int DATA_W  = 32,
  parameter int BEAT_W  = 16,
  parameter int PKT_W   = 16,
  parameter int GAP_W   = 8,
  parameter bit PACE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_clear,
  input  logic              ctl_start,
  input  logic [BEAT_W-1:0] cfg_beats_m1,
  input  logic [PKT_W-1:0]  cfg_pkts_m1,
  input  logic [GAP_W-1:0]  cfg_gap,
  output logic              busy,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tlast
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   srst_n;
  logic                   launch;
  logic                   accept;
  logic                   pace_ok;
  logic                   seq_busy;
  logic                   seq_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign srst_n = rst_pipe_q[SYNC_STAGES-1];

  assign m_tvalid = seq_busy && pace_ok;
  assign accept   = m_tvalid && m_tready;
  assign busy     = seq_busy;
  assign m_tlast  = seq_last;

  pktgen_seq #(.BEAT_W(BEAT_W), .PKT_W(PKT_W)) u_seq (
    .clk      (clk),
    .rst_n    (srst_n),
    .clear    (ctl_clear),
    .start    (ctl_start),
    .beats_m1 (cfg_beats_m1),
    .pkts_m1  (cfg_pkts_m1),
    .accept   (accept),
    .launch   (launch),
    .busy     (seq_busy),
    .last     (seq_last)
  );

  pktgen_pacer #(.GAP_W(GAP_W), .PACE_EN(PACE_EN)) u_pacer (
    .clk    (clk),
    .rst_n  (srst_n),
    .clear  (ctl_clear),
    .launch (launch),
    .accept (accept),
    .gap    (cfg_gap),
    .ready  (pace_ok)
  );

  pktgen_data #(.DATA_W(DATA_W)) u_data (
    .clk    (clk),
    .rst_n  (srst_n),
    .clear  (ctl_clear),
    .launch (launch),
    .accept (accept),
    .data   (m_tdata)
  );
endmodule

// File: rtl/axis_pktgen_chk.sv
module axis_pktgen_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_clear,
  input logic              ctl_start,
  input logic              busy,
  input logic              m_tvalid,
  input logic              m_tready,
  input logic [DATA_W-1:0] m_tdata,
  input logic              m_tlast
);
  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready && !ctl_clear |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));

  // R11
  valid_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> busy);

  // R10
  clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_clear |=> !busy && !m_tvalid);

  // R5
  data_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && m_tready && !ctl_clear |=> m_tdata == DATA_W'($past(m_tdata) + 1'b1));

  // R8
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !ctl_clear && !(m_tvalid && m_tready && m_tlast) |=> busy);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !m_tvalid && !m_tlast);
endmodule

bind axis_pktgen axis_pktgen_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_clear (ctl_clear),
  .ctl_start (ctl_start),
  .busy      (busy),
  .m_tvalid  (m_tvalid),
  .m_tready  (m_tready),
  .m_tdata   (m_tdata),
  .m_tlast   (m_tlast)
);

// File: tb/tb_axis_pktgen.sv
module tb_axis_pktgen;
  localparam int DATA_W = 32;
  localparam int BEAT_W = 16;
  localparam int PKT_W  = 16;
  localparam int GAP_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ctl_clear = 1'b0;
  logic              ctl_start = 1'b0;
  logic [BEAT_W-1:0] cfg_beats_m1 = '0;
  logic [PKT_W-1:0]  cfg_pkts_m1 = '0;
  logic [GAP_W-1:0]  cfg_gap = '0;
  logic              busy, m_tvalid, m_tlast;
  logic              m_tready = 1'b1;
  logic [DATA_W-1:0] m_tdata;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  axis_pktgen #(.DATA_W(DATA_W), .BEAT_W(BEAT_W), .PKT_W(PKT_W), .GAP_W(GAP_W)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_clear(ctl_clear), .ctl_start(ctl_start),
    .cfg_beats_m1(cfg_beats_m1), .cfg_pkts_m1(cfg_pkts_m1), .cfg_gap(cfg_gap),
    .busy(busy), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .m_tdata(m_tdata), .m_tlast(m_tlast)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // behavioural reference
  bit          r_busy;
  int          r_beat, r_pkt, r_pace, r_len, r_cnt, r_gap;
  longint      r_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_busy = 0; r_beat = 0; r_pkt = 0; r_pace = 0; r_data = 0;
      r_len = 0; r_cnt = 0; r_gap = 0;
    end else if (ctl_clear) begin
      r_busy = 0; r_beat = 0; r_pkt = 0; r_pace = 0; r_data = 0;
    end else if (ctl_start && !r_busy) begin
      r_busy = 1; r_beat = 0; r_pkt = 0; r_pace = 0; r_data = 0;
      r_len = int'(cfg_beats_m1); r_cnt = int'(cfg_pkts_m1); r_gap = int'(cfg_gap);
    end else if (r_busy && r_pace == 0 && m_tready) begin
      r_data = (r_data + 1) % (longint'(1) << DATA_W);
      r_pace = r_gap;
      if (r_beat == r_len) begin
        r_beat = 0;
        if (r_pkt == r_cnt) r_busy = 0;
        else r_pkt++;
      end else begin
        r_beat++;
      end
    end else if (r_pace > 0) begin
      r_pace--;
    end
  end

  // every-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit ev, el;
      ev = r_busy && (r_pace == 0);
      el = r_busy && (r_beat == r_len);
      chk(busy == r_busy, "R2/R4 busy", busy, r_busy);
      chk(m_tvalid == ev, "R7/R11 tvalid", m_tvalid, ev);
      chk(m_tlast == el, "R3/R9 tlast", m_tlast, el);
      if (ev) chk(longint'(m_tdata) == r_data, "R5/R6 tdata", m_tdata, r_data);
    end
  end

  // backpressure and accepted-beat tally
  bit      rand_ready = 0;
  logic [15:0] lfsr = 16'hACE1;
  int      n_beats = 0, n_lasts = 0;
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_tready = rand_ready ? lfsr[0] | lfsr[3] : 1'b1;
    if (rst_n && m_tvalid && m_tready) begin
      n_beats++;
      if (m_tlast) n_lasts++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic launch(input int len, input int cnt, input int gap);
    @(negedge clk);
    cfg_beats_m1 = BEAT_W'(len);
    cfg_pkts_m1  = PKT_W'(cnt);
    cfg_gap      = GAP_W'(gap);
    ctl_start    = 1;
    n_beats = 0; n_lasts = 0;
    @(negedge clk);
    ctl_start = 0;
  endtask

  task automatic run(input int len, input int cnt, input int gap, input string req);
    launch(len, cnt, gap);
    wait_idle();
    chk(n_lasts == cnt + 1, {req, " packets"}, n_lasts, cnt + 1);
    chk(n_beats == (len + 1) * (cnt + 1), {req, " beats"}, n_beats, (len + 1) * (cnt + 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state while held
    chk(!busy && !m_tvalid && !m_tlast, "R1 reset outputs", {busy, m_tvalid, m_tlast}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!busy && !m_tvalid && !m_tlast, "R1 after release", {busy, m_tvalid, m_tlast}, 0);

    // R2: start then immediate valid
    launch(3, 2, 0);
    chk(busy && m_tvalid, "R2 start", {busy, m_tvalid}, 3);
    wait_idle();
    chk(n_lasts == 3, "R3/R4 packets", n_lasts, 3);
    chk(n_beats == 12, "R4 beats", n_beats, 12);

    // random backpressure with spacing
    rand_ready = 1;
    run(4, 3, 2, "R6/R7");
    run(6, 1, 0, "R6");
    // R9 single-beat packets
    run(0, 5, 1, "R9");
    rand_ready = 0;
    run(0, 0, 0, "R9 one beat");

    // R8 start while busy and settings changed mid-run
    launch(2, 3, 0);
    repeat (2) @(negedge clk);
    cfg_beats_m1 = 0; cfg_pkts_m1 = 0; cfg_gap = 5; ctl_start = 1;
    @(negedge clk);
    ctl_start = 0;
    wait_idle();
    chk(n_lasts == 4, "R8 packets", n_lasts, 4);
    chk(n_beats == 12, "R8 beats", n_beats, 12);

    // R10 clear mid-run, together with start
    launch(7, 7, 0);
    repeat (5) @(negedge clk);
    ctl_clear = 1; ctl_start = 1;
    @(negedge clk);
    ctl_clear = 0; ctl_start = 0;
    chk(!busy && !m_tvalid, "R10 clear", {busy, m_tvalid}, 0);
    repeat (3) @(negedge clk);
    chk(!busy, "R10 stays idle", busy, 0);
    run(1, 1, 0, "R5 after clear");

    repeat (5) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule